// File: doc/BRIEF.md
# Stack and Interrupt Context Sequencer

This block owns the stack pointer of a small 32-bit processor with eight general registers (a to h, indices 0 to 7) and runs every control-flow path that goes through the stack: push, pop, loading and reading the stack pointer, subroutine call and return, interrupt entry and interrupt return. The stack grows toward higher addresses: a push writes at the stack pointer and then advances it by one word (4 bytes), and a pop first steps back one word and then reads. The decoder hands one command at a time on `cmd_valid`/`cmd_op`/`cmd_reg`, together with `cur_ip`, the address of the instruction being presented (or of the next one to fetch when no command is presented).

Stack traffic goes through a word memory port that carries one request at a time: `mem_req` is held with a stable address and data until `mem_ack`. Register values are read and written through a register-file port whose read data is combinational. Peripheral interrupt requests arrive as a level vector. Line 0 is also driven by an internal loopback latch that a software-interrupt command sets. When interrupts are open and a request is present at an instruction boundary, the block saves the return address and registers a to h, sets the inhibit flag and redirects the instruction pointer to the line's handler. The interrupt-return command undoes this in reverse order. Reloading the stack pointer inside a handler before that command therefore switches to another saved context.

The control is one state machine. Its states are IDLE, PUSH, POP, CALL, RET, ENTRY and IRET. The transitions are IDLE to ENTRY on an interrupt take, IDLE to PUSH, POP, CALL, RET or IRET when the matching command is accepted, PUSH, POP, CALL and RET to IDLE on the memory acknowledge, ENTRY to IDLE on the acknowledge of its ninth write, and IRET to IDLE on the acknowledge of its ninth read. `busy` is high in every state but IDLE, and also in the IDLE cycle where an interrupt is taken, so that fetch stalls.

Top module: `stk_ctx_seq`

## Requirements
- R1: After reset the stack pointer equals SP_INIT (0x100), the interrupt-inhibit output is 1, `busy` is 0 and no interrupt is acknowledged.
- R2: PUSH (opcode 1) writes register `cmd_reg` to memory at the stack pointer, then advances the stack pointer by 4.
- R3: POP (opcode 2) reads memory at the stack pointer minus 4, writes that word to register `cmd_reg`, and leaves the stack pointer 4 lower. A push followed by a pop restores both the value and the pointer.
- R4: SP_LOAD (opcode 3) loads the stack pointer from register `cmd_reg`. SP_READ (opcode 4) writes the stack pointer into register `cmd_reg` at the edge that accepts the command.
- R5: CALL (opcode 5) pushes `cur_ip`+4 and then loads the instruction pointer (`ip_load`/`ip_next`) with the value of register `cmd_reg`.
- R6: RET (opcode 6) pops one word and loads it into the instruction pointer.
- R7: Interrupt entry pushes `cur_ip`, then registers a through h in index order, sets the inhibit flag, and loads the instruction pointer with HANDLER_BASE + line × HANDLER_STRIDE (0x8000 + line × 0x40).
- R8: When several lines request together, the lowest-numbered line is taken. `irq_ack` is one-hot on that line for the single take cycle.
- R9: While the inhibit flag is 1, no request is taken. INH_SET (opcode 8) sets the flag and INH_CLR (opcode 9) clears it. Requests are only taken in IDLE, at an instruction boundary.
- R10: IRET (opcode 7) pops registers h down to a, then pops the return address into the instruction pointer, and clears the inhibit flag. After a stack-pointer reload in the handler, it restores the frame found at the new pointer.
- R11: SWI (opcode 10) sets a loopback request on line 0. The request stays pending while interrupts are inhibited and is cleared when line 0 is taken.
- R12: Only one memory request is outstanding. Its address, write enable and data stay stable until `mem_ack`, and `busy` is high for the whole of any multi-cycle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command presented. It is accepted when `busy` is 0 |
| cmd_op | input | 4 | Command opcode |
| cmd_reg | input | 3 | Register operand index (a=0 … h=7) |
| cur_ip | input | 32 | Address of the presented or next instruction |
| busy | output | 1 | Stall fetch: a sequence is running or an interrupt is being taken |
| ip_load | output | 1 | One-cycle pulse: load the instruction pointer |
| ip_next | output | 32 | New instruction pointer value when `ip_load` is high |
| irq_inhibit | output | 1 | Interrupt-inhibit flag |
| irq_req | input | 4 | Peripheral request lines (level) |
| irq_ack | output | 4 | One-hot acknowledge of the line being taken |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed. Read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A command is accepted at the edge where `busy` is low. Single-cycle commands (SP_LOAD, SP_READ, INH_SET, INH_CLR, SWI) take effect at that edge. Every stack access puts `mem_req` up in the next cycle, and the bench memory answers one cycle later, so each access costs two cycles. A push or pop therefore settles about three cycles after acceptance, and an entry or interrupt return of nine accesses settles about nineteen cycles after it starts. Interrupt takes happen in the first IDLE cycle after the inhibit flag clears. Rather than counting to a fixed edge, the bench waits for `busy` to fall at a falling edge and only then compares memory, registers and the captured `ip_next` and `irq_ack`. Absence checks hold the stimulus for 20 cycles before sampling.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_PUSH    = 4'd1,
        OP_POP     = 4'd2,
        OP_SP_LOAD = 4'd3,
        OP_SP_READ = 4'd4,
        OP_CALL    = 4'd5,
        OP_RET     = 4'd6,
        OP_IRET    = 4'd7,
        OP_INH_SET = 4'd8,
        OP_INH_CLR = 4'd9,
        OP_SWI     = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_POP,
        S_CALL,
        S_RET,
        S_ENTRY,
        S_IRET
    } state_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_INC,
        SP_DEC,
        SP_LOAD
    } sp_cmd_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned STEP    = 4,
    parameter logic [DW-1:0] INIT  = 'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_cmd_e       cmd,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_below
);

    localparam logic [DW-1:0] STEP_W = DW'(STEP);

    logic [DW-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= INIT;
        end else begin
            unique case (cmd)
                SP_INC:  sp_q <= sp_q + STEP_W;
                SP_DEC:  sp_q <= sp_q - STEP_W;
                SP_LOAD: sp_q <= load_val;
                default: sp_q <= sp_q;
            endcase
        end
    end

    assign sp       = sp_q;
    assign sp_below = sp_q - STEP_W;

endmodule

// File: rtl/stk_irq_arb.sv
module stk_irq_arb #(
    parameter int unsigned NLINES = 4,
    localparam int unsigned LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req,
    input  logic              swi_set,
    input  logic              take,
    output logic              any,
    output logic [LW-1:0]     line,
    output logic [NLINES-1:0] grant
);

    logic              loop_q;
    logic [NLINES-1:0] eff;

    always_comb begin
        eff    = req;
        eff[0] = req[0] | loop_q;
    end

    always_comb begin
        line = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (eff[i]) line = LW'(i);
        end
    end

    assign any = |eff;

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_grant
            assign grant[g] = take && (line == LW'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q <= 1'b0;
        end else if (swi_set) begin
            loop_q <= 1'b1;
        end else if (take && line == '0) begin
            loop_q <= 1'b0;
        end
    end

endmodule

// File: rtl/stk_ctx_seq.sv
module stk_ctx_seq
    import stk_pkg::*;
#(
    parameter int unsigned DW             = 32,
    parameter int unsigned NREG           = 8,
    parameter int unsigned NLINES         = 4,
    parameter int unsigned WORD_BYTES     = 4,
    parameter int unsigned SP_INIT        = 'h100,
    parameter int unsigned HANDLER_BASE   = 'h8000,
    parameter int unsigned HANDLER_STRIDE = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [2:0]        cmd_reg,
    input  logic [DW-1:0]     cur_ip,
    output logic              busy,
    output logic              ip_load,
    output logic [DW-1:0]     ip_next,
    output logic              irq_inhibit,
    input  logic [NLINES-1:0] irq_req,
    output logic [NLINES-1:0] irq_ack,
    output logic [2:0]        rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata
);

    localparam int unsigned RW = 3;
    localparam int unsigned CW = $clog2(NREG + 1);
    localparam int unsigned LW = (NLINES > 1) ? $clog2(NLINES) : 1;
    localparam logic [CW-1:0] LAST_SLOT = CW'(NREG);
    localparam logic [DW-1:0] H_BASE    = DW'(HANDLER_BASE);
    localparam logic [DW-1:0] H_STRIDE  = DW'(HANDLER_STRIDE);
    localparam logic [DW-1:0] CALL_OFS  = DW'(WORD_BYTES);

    state_e        state_q, state_d;
    logic [CW-1:0] slot_q;
    logic [LW-1:0] line_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] ret_q;
    logic [RW-1:0] reg_q;
    logic          inh_q;

    sp_cmd_e       sp_cmd;
    logic [DW-1:0] sp;
    logic [DW-1:0] sp_below;

    logic              irq_any;
    logic [LW-1:0]     irq_line;
    logic              take;
    logic              swi_set;
    logic              accept;
    op_e               op;
    logic [DW-1:0]     handler_addr;

    assign op           = op_e'(cmd_op);
    assign take         = (state_q == S_IDLE) && !inh_q && irq_any;
    assign accept       = (state_q == S_IDLE) && !take && cmd_valid;
    assign busy         = (state_q != S_IDLE) || take;
    assign irq_inhibit  = inh_q;
    assign handler_addr = H_BASE + DW'(line_q) * H_STRIDE;

    stk_ptr #(
        .DW   (DW),
        .STEP (WORD_BYTES),
        .INIT (DW'(SP_INIT))
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (sp_cmd),
        .load_val (rf_rdata),
        .sp       (sp),
        .sp_below (sp_below)
    );

    stk_irq_arb #(
        .NLINES (NLINES)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .swi_set (swi_set),
        .take    (take),
        .any     (irq_any),
        .line    (irq_line),
        .grant   (irq_ack)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers captured on acceptance or acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            line_q <= '0;
            data_q <= '0;
            ret_q  <= '0;
            reg_q  <= '0;
            inh_q  <= 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    slot_q <= '0;
                    if (take) begin
                        ret_q  <= cur_ip;
                        line_q <= irq_line;
                    end else if (cmd_valid) begin
                        reg_q  <= cmd_reg;
                        data_q <= rf_rdata;
                        ret_q  <= cur_ip + CALL_OFS;
                        if (op == OP_INH_SET) inh_q <= 1'b1;
                        if (op == OP_INH_CLR) inh_q <= 1'b0;
                    end
                end
                S_ENTRY: begin
                    if (mem_ack) begin
                        slot_q <= slot_q + 1'b1;
                        if (slot_q == LAST_SLOT) inh_q <= 1'b1;
                    end
                end
                S_IRET: begin
                    if (mem_ack) begin
                        slot_q <= slot_q + 1'b1;
                        if (slot_q == LAST_SLOT) inh_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        sp_cmd    = SP_HOLD;
        swi_set   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp;
        mem_wdata = data_q;
        rf_raddr  = cmd_reg;
        rf_we     = 1'b0;
        rf_waddr  = reg_q;
        rf_wdata  = mem_rdata;
        ip_load   = 1'b0;
        ip_next   = mem_rdata;

        unique case (state_q)
            S_IDLE: begin
                if (take) begin
                    state_d = S_ENTRY;
                end else if (accept) begin
                    unique case (op)
                        OP_PUSH:    state_d = S_PUSH;
                        OP_POP:     state_d = S_POP;
                        OP_CALL:    state_d = S_CALL;
                        OP_RET:     state_d = S_RET;
                        OP_IRET:    state_d = S_IRET;
                        OP_SP_LOAD: sp_cmd  = SP_LOAD;
                        OP_SP_READ: begin
                            rf_we    = 1'b1;
                            rf_waddr = cmd_reg;
                            rf_wdata = sp;
                        end
                        OP_SWI:     swi_set = 1'b1;
                        default: ;
                    endcase
                end
            end
            S_PUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    sp_cmd  = SP_INC;
                    state_d = S_IDLE;
                end
            end
            S_POP: begin
                mem_req  = 1'b1;
                mem_addr = sp_below;
                if (mem_ack) begin
                    rf_we   = 1'b1;
                    sp_cmd  = SP_DEC;
                    state_d = S_IDLE;
                end
            end
            S_CALL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ret_q;
                if (mem_ack) begin
                    sp_cmd  = SP_INC;
                    ip_load = 1'b1;
                    ip_next = data_q;
                    state_d = S_IDLE;
                end
            end
            S_RET: begin
                mem_req  = 1'b1;
                mem_addr = sp_below;
                if (mem_ack) begin
                    sp_cmd  = SP_DEC;
                    ip_load = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_ENTRY: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                rf_raddr  = RW'(slot_q - 1'b1);
                mem_wdata = (slot_q == '0) ? ret_q : rf_rdata;
                if (mem_ack) begin
                    sp_cmd = SP_INC;
                    if (slot_q == LAST_SLOT) begin
                        ip_load = 1'b1;
                        ip_next = handler_addr;
                        state_d = S_IDLE;
                    end
                end
            end
            S_IRET: begin
                mem_req  = 1'b1;
                mem_addr = sp_below;
                rf_waddr = RW'(LAST_SLOT - 1'b1 - slot_q);
                if (mem_ack) begin
                    sp_cmd = SP_DEC;
                    if (slot_q == LAST_SLOT) begin
                        ip_load = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        rf_we = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

endmodule

// File: rtl/stk_ctx_chk.sv
module stk_ctx_chk #(
    parameter int unsigned DW         = 32,
    parameter int unsigned NLINES     = 4,
    parameter int unsigned WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic              busy,
    input logic              ip_load,
    input logic              irq_inhibit,
    input logic [NLINES-1:0] irq_ack,
    input logic              rf_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_ack,
    input logic [DW-1:0]     sp
);

    localparam logic [DW-1:0] STEP_W = DW'(WORD_BYTES);

    // R12: a pending request holds its address, direction and data
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12: memory traffic only while fetch is stalled
    p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R2: every acknowledged write advances the pointer by one word
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (sp == $past(sp) + STEP_W));

    // R3: every acknowledged read steps the pointer back by one word
    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (sp == $past(sp) - STEP_W));

    // R8: at most one line acknowledged
    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    // R9: no take while inhibited
    p_ack_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> !irq_inhibit);

    // R10: inhibit clears only by INH_CLR or at the end of an interrupt return
    p_open_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_inhibit) |-> ($past(ip_load) || $past(cmd_valid && !busy && cmd_op == 4'd9)));

    // R3: a register write never overlaps a memory write
    p_rf_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !(mem_req && mem_we));

endmodule

bind stk_ctx_seq stk_ctx_chk #(
    .DW         (DW),
    .NLINES     (NLINES),
    .WORD_BYTES (WORD_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .busy        (busy),
    .ip_load     (ip_load),
    .irq_inhibit (irq_inhibit),
    .irq_ack     (irq_ack),
    .rf_we       (rf_we),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .sp          (sp)
);

// File: tb/tb_stk_ctx_seq.sv
module tb_stk_ctx_seq;

    localparam logic [3:0] OP_PUSH = 4'd1, OP_POP = 4'd2, OP_SPLD = 4'd3, OP_SPRD = 4'd4,
                           OP_CALL = 4'd5, OP_RET = 4'd6, OP_IRET = 4'd7,
                           OP_ISET = 4'd8, OP_ICLR = 4'd9, OP_SWI = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_reg = '0;
    logic [31:0] cur_ip = 32'h2000;
    logic        busy, ip_load, irq_inhibit;
    logic [31:0] ip_next;
    logic [3:0]  irq_req = '0;
    logic [3:0]  irq_ack;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;

    logic [31:0] rf  [8];
    logic [31:0] mem [256];

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int ip_cnt = 0;
    int ack_cnt = 0;
    logic [31:0] last_ip = '0;
    logic [3:0]  last_ack = '0;

    always #10 clk = ~clk;

    stk_ctx_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
        .cur_ip(cur_ip), .busy(busy), .ip_load(ip_load), .ip_next(ip_next),
        .irq_inhibit(irq_inhibit), .irq_req(irq_req), .irq_ack(irq_ack),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) rf[i] = '0;
    end

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    always @(posedge clk) begin
        if (rst_n && ip_load) begin
            ip_cnt  <= ip_cnt + 1;
            last_ip <= ip_next;
        end
        if (rst_n && irq_ack != 0) begin
            ack_cnt  <= ack_cnt + 1;
            last_ack <= irq_ack;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [2:0] r);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_reg   = r;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_sp(output logic [31:0] v);
        issue(OP_SPRD, 3'd7);
        v = rf[7];
    endtask

    task automatic set_sp(input logic [31:0] v);
        @(negedge clk);
        rf[6] = v;
        issue(OP_SPLD, 3'd6);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 inhibit", {31'd0, irq_inhibit}, 32'd1);
        chk("R1 ack", {28'd0, irq_ack}, 32'd0);
        read_sp(v);
        chk("R1 sp", v, 32'h100);
    endtask

    task automatic t_push_pop();
        logic [31:0] v;
        set_sp(32'h140);
        rf[0] = 32'hA5A5_0001;
        issue(OP_PUSH, 3'd0);
        chk("R12 busy during push", {31'd0, busy}, 32'd1);
        wait_idle();
        chk("R2 push data", mem[32'h140 >> 2], 32'hA5A5_0001);
        read_sp(v);
        chk("R2 push sp", v, 32'h144);
        rf[1] = '0;
        issue(OP_POP, 3'd1);
        wait_idle();
        chk("R3 pop data", rf[1], 32'hA5A5_0001);
        read_sp(v);
        chk("R3 pop sp", v, 32'h140);
    endtask

    task automatic t_sp_load();
        logic [31:0] v;
        set_sp(32'h1F0);
        read_sp(v);
        chk("R4 sp load/read", v, 32'h1F0);
        rf[2] = 32'h0BAD_F00D;
        issue(OP_PUSH, 3'd2);
        wait_idle();
        chk("R4 push at loaded sp", mem[32'h1F0 >> 2], 32'h0BAD_F00D);
    endtask

    task automatic t_call_ret();
        logic [31:0] v;
        int n0;
        set_sp(32'h180);
        rf[3] = 32'h0000_4400;
        cur_ip = 32'h1000;
        n0 = ip_cnt;
        issue(OP_CALL, 3'd3);
        wait_idle();
        @(negedge clk);
        chk("R5 call ip", last_ip, 32'h4400);
        chk("R5 call one load", ip_cnt - n0, 1);
        chk("R5 call saved", mem[32'h180 >> 2], 32'h1004);
        issue(OP_RET, 3'd0);
        wait_idle();
        @(negedge clk);
        chk("R6 ret ip", last_ip, 32'h1004);
        read_sp(v);
        chk("R6 ret sp", v, 32'h180);
    endtask

    task automatic t_inhibited();
        int a0, n0;
        a0 = ack_cnt;
        n0 = ip_cnt;
        issue(OP_ISET, 3'd0);
        irq_req = 4'b1000;
        wait_cycles(20);
        chk("R9 no take while inhibited", ack_cnt - a0, 0);
        chk("R9 no redirect while inhibited", ip_cnt - n0, 0);
        chk("R9 not busy", {31'd0, busy}, 32'd0);
        irq_req = '0;
    endtask

    task automatic t_entry_iret();
        logic [31:0] v;
        set_sp(32'h100);
        for (int i = 0; i < 8; i++) rf[i] = 32'h1111_0000 + i;
        cur_ip  = 32'h2000;
        irq_req = 4'b0110;
        issue(OP_ICLR, 3'd0);
        wait_idle();
        @(negedge clk);
        irq_req = '0;
        chk("R8 lowest line wins", {28'd0, last_ack}, 32'h2);
        chk("R7 handler ip", last_ip, 32'h8040);
        chk("R7 inhibit set", {31'd0, irq_inhibit}, 32'd1);
        chk("R7 ret slot", mem[32'h100 >> 2], 32'h2000);
        for (int i = 0; i < 8; i++)
            chk("R7 reg slot", mem[(32'h104 >> 2) + i], 32'h1111_0000 + i);
        // save sp into h then restore h to keep the frame compare clean
        read_sp(v);
        chk("R7 sp after entry", v, 32'h124);
        for (int i = 0; i < 8; i++) rf[i] = 32'hDEAD_0000;
        issue(OP_IRET, 3'd0);
        wait_idle();
        @(negedge clk);
        for (int i = 0; i < 8; i++)
            chk("R10 reg restored", rf[i], 32'h1111_0000 + i);
        chk("R10 return ip", last_ip, 32'h2000);
        chk("R10 inhibit cleared", {31'd0, irq_inhibit}, 32'd0);
        read_sp(v);
        chk("R10 sp restored", v, 32'h100);
    endtask

    task automatic t_context_switch();
        logic [31:0] v;
        // build a second frame at 0x200: return address then a..h
        mem[32'h200 >> 2] = 32'h3300;
        for (int i = 0; i < 8; i++) mem[(32'h204 >> 2) + i] = 32'h2222_0000 + i;
        set_sp(32'h300);
        for (int i = 0; i < 8; i++) rf[i] = 32'h5555_0000 + i;
        irq_req = 4'b0100;
        wait_idle();
        wait_cycles(2);
        wait_idle();
        @(negedge clk);
        irq_req = '0;
        chk("R7 line 2 handler", last_ip, 32'h8080);
        set_sp(32'h224);
        issue(OP_IRET, 3'd0);
        wait_idle();
        @(negedge clk);
        for (int i = 0; i < 8; i++)
            chk("R10 switched reg", rf[i], 32'h2222_0000 + i);
        chk("R10 switched ip", last_ip, 32'h3300);
        read_sp(v);
        chk("R10 switched sp", v, 32'h200);
    endtask

    task automatic t_swi();
        int a0;
        set_sp(32'h100);
        issue(OP_ISET, 3'd0);
        a0 = ack_cnt;
        issue(OP_SWI, 3'd0);
        wait_cycles(20);
        chk("R11 held while inhibited", ack_cnt - a0, 0);
        issue(OP_ICLR, 3'd0);
        wait_idle();
        @(negedge clk);
        chk("R11 loopback line 0", {28'd0, last_ack}, 32'h1);
        chk("R11 handler 0", last_ip, 32'h8000);
        chk("R11 taken once", ack_cnt - a0, 1);
        issue(OP_IRET, 3'd0);
        wait_idle();
        wait_cycles(20);
        chk("R11 pending cleared", ack_cnt - a0, 1);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_sp_load();
        t_call_ret();
        t_inhibited();
        t_entry_iret();
        t_context_switch();
        t_swi();
        summary();
    end

endmodule